// File: doc/BRIEF.md
# Touch-Codec ADC Conversion Sequencer

This block is the control half of a multiplexed 10-bit converter inside a mixed-signal codec. A host reaches it through a small register interface with 4-bit indices and 16-bit data. One register holds the converter's control fields: power, reference options, input choice, sync gating and a start bit. A second register returns the latest result, left-justified, with a valid flag on top. The analog converter is replaced by a behavioural sample input that the block captures when a conversion ends.

All timing is counted in serial-bus clocks, one per `clk` cycle. Powering the converter first runs a reference warm-up. Each conversion then has an input-settling phase and a conversion phase. It can optionally wait for an edge on an external sync pin between those two phases. Completion raises bit 11 of an event vector that feeds the codec's interrupt logic.

Top module: `tcadc_seq`

## Requirements
- R1: After synchronous reset, the control register (index 0xA) and the data register (index 0xB) both read 0x0000, and `evt_o` is 0.
- R2: Index 0xA holds the control fields: bit 15 power-on, bit 7 start, bit 5 external reference, bits 4:2 input code, bit 1 reference bypass, bit 0 sync gating. The other bits read 0. `sel_o`, `ref_ext_o` and `ref_byp_o` follow the stored fields. Input codes 0–3 are the touch lines and 4–7 are auxiliary inputs 0–3.
- R3: After power-on, a warm-up of REF_CLKS (60) clocks runs before the first settle phase. If power-on and start are written together, the valid flag appears 2+REF_CLKS+SETTLE_CLKS+CONV_CLKS = 215 clocks after the write edge.
- R4: With the converter already warm, a start leads to SETTLE_CLKS (51) settle clocks, then CONV_CLKS (102) conversion clocks. The valid flag appears 154 clocks after the write edge.
- R5: At index 0xB, bit 15 is the valid flag and bits 14:5 hold `sample_i` as captured on the last conversion clock. Bits 4:0 read 0.
- R6: A control write that takes the start bit from 0 to 1 while power-on is set clears the valid flag at once. Otherwise the flag stays set, including across control writes that do not raise start.
- R7: With sync gating set, a conversion holds after its settle phase until `sync_i` rises. It completes CONV_CLKS clocks after the clock edge that sees the rise.
- R8: Each completion sets `evt_o` to 0x0800 (only bit 11) for exactly one clock. At all other times `evt_o` is 0.
- R9: Clearing power-on aborts any conversion in progress. No valid flag and no event follow. A later power-on repeats the full warm-up.
- R10: A control write with power-on clear stores the start bit as 0 and starts nothing.
- R11: A start raised while a conversion is running is queued. It begins one clock after the running conversion completes, so its result arrives 154 clocks after the first one.
- R12: Indices other than 0xA and 0xB read 0x0000, and writes to them leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-bus clock; all timing counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write index |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 4 | Register read index |
| rd_data_o | output | 16 | Combinational read data for `rd_addr_i` |
| sync_i | input | 1 | External conversion trigger |
| sample_i | input | 10 | Behavioural converter output |
| sel_o | output | 3 | Selected analog input code |
| ref_ext_o | output | 1 | External reference selected |
| ref_byp_o | output | 1 | Reference bypass connected |
| evt_o | output | 16 | Interrupt source vector, bit 11 = conversion done |

## Verification
The scoreboard predicts the exact clock of every completion event. A design that skips the warm-up, drops the extra idle hop, or miscounts a phase by one clock delivers its event on the wrong cycle. A design that starts conversion without waiting for a fresh sync edge, or lets an aborted conversion finish, produces an event the scoreboard never expected. Reads of the data register around each start catch a valid flag that is not cleared by a start, or is wrongly cleared by a write that does not raise start. A queued second start catches a design that drops requests made while it is busy.

// File: rtl/tcadc_pkg.sv
package tcadc_pkg;

    localparam int REG_AW = 4;
    localparam int REG_DW = 16;
    localparam int RES_W  = 10;

    localparam logic [REG_AW-1:0] IDX_CTRL = 4'hA;
    localparam logic [REG_AW-1:0] IDX_DATA = 4'hB;

    // control-word bit positions (decoded by host software)
    localparam int CB_PWR   = 15;
    localparam int CB_GO    = 7;
    localparam int CB_EXT   = 5;
    localparam int CB_SEL   = 2;
    localparam int CB_BYP   = 1;
    localparam int CB_SYNC  = 0;

    // data-word layout
    localparam int DB_VALID = 15;
    localparam int DB_RES   = 5;

    // interrupt source index for conversion done
    localparam int EVT_ADC  = 11;

    typedef struct packed {
        logic       pwr;
        logic       go;
        logic       ext;
        logic [2:0] sel;
        logic       byp;
        logic       sync;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WARM,
        ST_IDLE,
        ST_SETTLE,
        ST_WSYNC,
        ST_CONV
    } seq_st_t;

    function automatic ctrl_t decode_ctrl(input logic [REG_DW-1:0] w);
        ctrl_t c;
        c.pwr  = w[CB_PWR];
        c.go   = w[CB_GO] & w[CB_PWR];
        c.ext  = w[CB_EXT];
        c.sel  = w[CB_SEL +: 3];
        c.byp  = w[CB_BYP];
        c.sync = w[CB_SYNC];
        return c;
    endfunction

    function automatic logic [REG_DW-1:0] encode_ctrl(input ctrl_t c);
        logic [REG_DW-1:0] w;
        w = '0;
        w[CB_PWR]      = c.pwr;
        w[CB_GO]       = c.go;
        w[CB_EXT]      = c.ext;
        w[CB_SEL +: 3] = c.sel;
        w[CB_BYP]      = c.byp;
        w[CB_SYNC]     = c.sync;
        return w;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tcadc_ctrl.sv
module tcadc_ctrl
    import tcadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [REG_DW-1:0] wr_data_i,
    output ctrl_t             ctrl_o,
    output logic              start_req_o
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_nxt;
    logic  hit;

    assign hit      = wr_en_i && (wr_addr_i == IDX_CTRL);
    assign ctrl_nxt = decode_ctrl(wr_data_i);

    // start accepted only on a 0->1 transition of the stored bit
    assign start_req_o = hit && ctrl_nxt.go && !ctrl_q.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (hit) begin
            ctrl_q <= ctrl_nxt;
        end
    end

    assign ctrl_o = ctrl_q;

    AST_GO_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        (hit && !wr_data_i[CB_PWR]) |=> !ctrl_o.go); // R10

    AST_OTHER_IDX_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en_i && wr_addr_i == IDX_CTRL)) |=> $stable(ctrl_o)); // R12

endmodule

// File: rtl/tcadc_fsm.sv
module tcadc_fsm
    import tcadc_pkg::*;
#(
    parameter int REF_CLKS    = 60,
    parameter int SETTLE_CLKS = 51,
    parameter int CONV_CLKS   = 102
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pwr_i,
    input  logic    sync_mode_i,
    input  logic    sync_i,
    input  logic    start_req_i,
    output logic    done_o,
    output seq_st_t st_o
);

    localparam int MAXC = max3(REF_CLKS, SETTLE_CLKS, CONV_CLKS);
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    seq_st_t       st;
    logic [CW-1:0] cnt;
    logic          pend;
    logic          sync_q;
    logic          sync_rise;

    assign sync_rise = sync_i && !sync_q;
    assign done_o    = pwr_i && (st == ST_CONV) && (cnt == '0);
    assign st_o      = st;

    // queued start request
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (start_req_i) begin
            pend <= 1'b1;
        end else if (!pwr_i || st == ST_IDLE) begin
            pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_OFF;
            cnt    <= '0;
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_i;
            if (!pwr_i) begin
                st  <= ST_OFF;
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_OFF: begin
                        st  <= ST_WARM;
                        cnt <= CW'(REF_CLKS - 1);
                    end
                    ST_WARM: begin
                        if (cnt == '0) st <= ST_IDLE;
                        else           cnt <= cnt - 1'b1;
                    end
                    ST_IDLE: begin
                        if (pend) begin
                            st  <= ST_SETTLE;
                            cnt <= CW'(SETTLE_CLKS - 1);
                        end
                    end
                    ST_SETTLE: begin
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else if (sync_mode_i) begin
                            st <= ST_WSYNC;
                        end else begin
                            st  <= ST_CONV;
                            cnt <= CW'(CONV_CLKS - 1);
                        end
                    end
                    ST_WSYNC: begin
                        if (sync_rise) begin
                            st  <= ST_CONV;
                            cnt <= CW'(CONV_CLKS - 1);
                        end
                    end
                    ST_CONV: begin
                        if (cnt == '0) st <= ST_IDLE;
                        else           cnt <= cnt - 1'b1;
                    end
                    default: st <= ST_OFF;
                endcase
            end
        end
    end

    AST_ABORT_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        !pwr_i |=> (st == ST_OFF)); // R9

    AST_WARM_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_i) |=> (st == ST_WARM)); // R3

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WSYNC && pwr_i && !(sync_i && !sync_q)) |=> (st == ST_WSYNC)); // R7

    AST_DONE_FROM_CONV: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (st == ST_IDLE)); // R4

endmodule

// File: rtl/tcadc_result.sv
module tcadc_result
    import tcadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req_i,
    input  logic              done_i,
    input  logic [RES_W-1:0]  sample_i,
    output logic [REG_DW-1:0] data_o,
    output logic [REG_DW-1:0] evt_o
);

    localparam logic [REG_DW-1:0] EVT_MASK = REG_DW'(1) << EVT_ADC;

    logic             valid_q;
    logic [RES_W-1:0] res_q;
    logic             evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
            evt_q   <= 1'b0;
        end else begin
            evt_q <= done_i;
            if (done_i) begin
                res_q <= sample_i;
            end
            if (start_req_i) begin
                valid_q <= 1'b0;
            end else if (done_i) begin
                valid_q <= 1'b1;
            end
        end
    end

    always_comb begin
        data_o = '0;
        data_o[DB_VALID]       = valid_q;
        data_o[DB_RES +: RES_W] = res_q;
    end

    assign evt_o = evt_q ? EVT_MASK : '0;

    AST_GO_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
        start_req_i |=> !data_o[DB_VALID]); // R6

    AST_EVT_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (evt_o != '0) |=> (evt_o == '0)); // R8

    AST_EVT_ONLY_BIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_o) && ((evt_o & ~EVT_MASK) == '0)); // R8

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (data_o[DB_VALID] && !start_req_i) |=> data_o[DB_VALID]); // R6

endmodule

// File: rtl/tcadc_seq.sv
module tcadc_seq
    import tcadc_pkg::*;
#(
    parameter int REF_CLKS    = 60,
    parameter int SETTLE_CLKS = 51,
    parameter int CONV_CLKS   = 102
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [3:0]  wr_addr_i,
    input  logic [15:0] wr_data_i,
    input  logic [3:0]  rd_addr_i,
    output logic [15:0] rd_data_o,
    input  logic        sync_i,
    input  logic [9:0]  sample_i,
    output logic [2:0]  sel_o,
    output logic        ref_ext_o,
    output logic        ref_byp_o,
    output logic [15:0] evt_o
);

    ctrl_t             ctrl;
    logic              start_req;
    logic              done;
    seq_st_t           st;
    logic [REG_DW-1:0] data_word;

    tcadc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .ctrl_o      (ctrl),
        .start_req_o (start_req)
    );

    tcadc_fsm #(
        .REF_CLKS    (REF_CLKS),
        .SETTLE_CLKS (SETTLE_CLKS),
        .CONV_CLKS   (CONV_CLKS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pwr_i       (ctrl.pwr),
        .sync_mode_i (ctrl.sync),
        .sync_i      (sync_i),
        .start_req_i (start_req),
        .done_o      (done),
        .st_o        (st)
    );

    tcadc_result u_res (
        .clk         (clk),
        .rst         (rst),
        .start_req_i (start_req),
        .done_i      (done),
        .sample_i    (sample_i),
        .data_o      (data_word),
        .evt_o       (evt_o)
    );

    always_comb begin
        unique case (rd_addr_i)
            IDX_CTRL: rd_data_o = encode_ctrl(ctrl);
            IDX_DATA: rd_data_o = data_word;
            default:  rd_data_o = '0;
        endcase
    end

    assign sel_o     = ctrl.sel;
    assign ref_ext_o = ctrl.ext;
    assign ref_byp_o = ctrl.byp;

    AST_NO_EVT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pwr && st == ST_OFF) |=> (evt_o == '0)); // R9

endmodule

// File: tb/test_tcadc_seq.sv
module test_tcadc_seq;

    localparam int CLK_PERIOD = 10;
    localparam int L_WARM = 215;
    localparam int L_HOT  = 154;
    localparam int L_CONV = 102;
    localparam logic [3:0] A_CTRL = 4'hA;
    localparam logic [3:0] A_DATA = 4'hB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = A_DATA;
    logic [15:0] rd_data;
    logic        sync_in = 1'b0;
    logic [9:0]  sample = '0;
    logic [2:0]  sel;
    logic        rext, rbyp;
    logic [15:0] evt;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct { int at; logic [15:0] data; } exp_t;
    exp_t sb[$];

    tcadc_seq i_tcadc_seq (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .sync_i(sync_in), .sample_i(sample),
        .sel_o(sel), .ref_ext_o(rext), .ref_byp_o(rbyp), .evt_o(evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, output int ce);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        ce = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = rd_data;
        rd_addr = A_DATA;
    endtask

    function automatic logic [15:0] dword(input logic [9:0] s);
        return {1'b1, s, 5'b0};
    endfunction

    task automatic push(input int at, input logic [15:0] d);
        exp_t e;
        e.at = at; e.data = d;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops expected completions and compares timing, vector, data
    always @(negedge clk) begin
        #2;
        if (!rst && evt != 16'h0) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected event", evt, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.at, "R3/R4/R7/R11 event cycle", cyc, e.at);
                chk(evt == 16'h0800, "R8 event vector", evt, 16'h0800);
                if (rd_addr == A_DATA)
                    chk(rd_data == e.data, "R5 data at event", rd_data, e.data);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ce, ce1;
        logic [15:0] v;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v); chk(v == 16'h0, "R1 ctrl after reset", v, 0);
        rd(A_DATA, v); chk(v == 16'h0, "R1 data after reset", v, 0);
        chk(evt == 16'h0, "R1 event after reset", evt, 0);
        rd(4'h3, v);   chk(v == 16'h0, "R12 unused index", v, 0);

        // R10 start while powered down
        wr(A_CTRL, 16'h0094, ce);
        rd(A_CTRL, v); chk(v == 16'h0014, "R10 start dropped when off", v, 16'h0014);
        repeat (300) @(negedge clk);
        rd(A_DATA, v); chk(v[15] == 1'b0, "R10 no result when off", v[15], 0);

        // R3 power-on with start: warm-up + settle + convert
        sample = 10'h2A5;
        wr(A_CTRL, 16'h8088, ce);
        push(ce + L_WARM, dword(10'h2A5));
        chk(sel == 3'd2, "R2 sel output", sel, 2);
        drain();
        rd(A_DATA, v); chk(v == dword(10'h2A5), "R5 data layout", v, dword(10'h2A5));

        // R6 valid persistence and clearing; R4 warm timing
        repeat (50) @(negedge clk);
        rd(A_DATA, v); chk(v[15] == 1'b1, "R6 valid holds", v[15], 1);
        wr(A_CTRL, 16'h8008, ce);
        rd(A_DATA, v); chk(v[15] == 1'b1, "R6 valid holds over non-start write", v[15], 1);
        sample = 10'h155;
        wr(A_CTRL, 16'h8088, ce);
        push(ce + L_HOT, dword(10'h155));
        rd(A_DATA, v); chk(v[15] == 1'b0, "R6 start clears valid", v[15], 0);
        drain();

        // R2 field readback, R12 foreign writes
        wr(A_CTRL, 16'h803E, ce);
        rd(A_CTRL, v); chk(v == 16'h803E, "R2 ctrl readback", v, 16'h803E);
        chk(rext == 1'b1 && rbyp == 1'b1 && sel == 3'd7, "R2 decoded outputs",
            {rext, rbyp, sel}, 5'b11111);
        wr(4'h5, 16'hFFFF, ce);
        rd(A_CTRL, v); chk(v == 16'h803E, "R12 foreign write ignored", v, 16'h803E);
        rd(4'h5, v);   chk(v == 16'h0, "R12 foreign index reads zero", v, 0);

        // R7 sync gating
        sample = 10'h3FF;
        wr(A_CTRL, 16'h8085, ce);
        repeat (300) @(negedge clk);
        rd(A_DATA, v); chk(v[15] == 1'b0, "R7 waits for sync", v[15], 0);
        @(negedge clk);
        sync_in = 1'b1;
        push(cyc + 1 + L_CONV, dword(10'h3FF));
        drain();
        sync_in = 1'b0;

        // R9 abort then re-power
        wr(A_CTRL, 16'h8000, ce);
        sample = 10'h0AA;
        wr(A_CTRL, 16'h8080, ce);
        repeat (100) @(negedge clk);
        wr(A_CTRL, 16'h0000, ce);
        repeat (400) @(negedge clk);
        rd(A_DATA, v); chk(v[15] == 1'b0, "R9 abort leaves no valid", v[15], 0);
        rd(A_CTRL, v); chk(v == 16'h0, "R9 ctrl off", v, 0);
        sample = 10'h001;
        wr(A_CTRL, 16'h8080, ce);
        push(ce + L_WARM, dword(10'h001));
        drain();

        // R11 start queued during a conversion
        wr(A_CTRL, 16'h8000, ce);
        sample = 10'h0F0;
        wr(A_CTRL, 16'h8080, ce1);
        push(ce1 + L_HOT, dword(10'h0F0));
        repeat (60) @(negedge clk);
        wr(A_CTRL, 16'h8000, ce);
        wr(A_CTRL, 16'h8080, ce);
        push(ce1 + 2 * L_HOT, dword(10'h0F0));
        drain();

        chk(sb.size() == 0, "R8 all events seen", sb.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule